// File: doc/BRIEF.md
# Packet Rate Follower Regulator

This block keeps a local frame transmitter running at the same average rate as an upstream frame source whose oscillator differs slightly from the local one. It counts frames arriving (`rx_frame`) and frames leaving (`tx_frame`). The difference between the two is the fill level of a downstream frame buffer that holds three milliseconds of traffic. The frames themselves are not stored here. Only the fill level is tracked.

Once per control window of `MS_CYCLES` clocks (one millisecond), the block compares the fill level with the buffer midpoint. If the fill is too high, the send-tick period is shortened by one step. If it is too low, the period is lengthened by one step. Inside a tolerance band the period is left alone. The total correction is bounded so that the reload never strays more than one percent from nominal. A free-running timer issues `send_tick` once per trimmed period, and the transmit path uses that pulse to pace outgoing frames.

Top module: `rate_follower`

## Requirements
- R1: A cycle with `rx_frame` high and `tx_frame` low raises `occupancy` by one. A cycle with `tx_frame` high and `rx_frame` low lowers it by one. The new value is visible after the next rising clock edge.
- R2: When both strobes are high, or both are low, `occupancy` keeps its value.
- R3: `occupancy` never exceeds DEPTH = FRAMES_PER_MS*BUF_MS (12 by default). `overflow` is high exactly when `occupancy` equals DEPTH. Further receive-only cycles leave it at DEPTH.
- R4: `occupancy` never goes below 0. `underflow` is high exactly when `occupancy` is 0. Further send-only cycles leave it at 0.
- R5: Synchronous active-high `rst` sets `occupancy` to 0 (so `underflow` is 1), clears the trim so that `reload_out` equals `nominal_reload`, and restarts the control window and the tick timer.
- R6: `reload_out` changes only on the last cycle of each control window of `MS_CYCLES` clocks counted from reset release. It changes by at most one step per window.
- R7: If `occupancy` is greater than DEPTH/2 + `band` at a window end, `reload_out` drops by `trim_step`.
- R8: If `occupancy` + `band` is less than DEPTH/2 at a window end, `reload_out` rises by `trim_step`.
- R9: If `occupancy` lies between DEPTH/2 - `band` and DEPTH/2 + `band`, both bounds included, `reload_out` is unchanged at the window end.
- R10: `reload_out` stays within `nominal_reload` ± floor(`nominal_reload`/100). A step that would cross a bound stops at the bound.
- R11: `send_tick` is a one-cycle pulse that repeats every `reload_out` cycles while `reload_out` is steady. `reload_out` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_frame | input | 1 | One-cycle strobe per received frame |
| tx_frame | input | 1 | One-cycle strobe per sent frame |
| nominal_reload | input | RELOAD_W | Untrimmed send-tick period in clocks |
| trim_step | input | STEP_W | Reload change applied per adjustment |
| band | input | OCC_W | Tolerance around the midpoint, in frames |
| reload_out | output | RELOAD_W | Trimmed send-tick period |
| send_tick | output | 1 | Pulse once per trimmed period |
| occupancy | output | OCC_W | Received-minus-sent frame count |
| underflow | output | 1 | Occupancy is at zero |
| overflow | output | 1 | Occupancy is at DEPTH |

## Verification
The hardest states to reach are those where the trim sits against one of its one-percent bounds, and the cases where the fill level rests exactly on a band edge when a window closes. Reaching either means holding the count at a chosen value across many whole windows. The bench shortens the window through the `MS_CYCLES` parameter and steers `occupancy` to an exact value with receive-only or send-only strobes. It then waits a whole number of windows, so exactly the intended number of adjustments take place. A bench-side model of the requirements follows every cycle, so that adjustments taken during the table walk are checked as well.

// File: rtl/rate_follow_pkg.sv
package rate_follow_pkg;

    typedef enum logic [1:0] {
        ADJ_HOLD     = 2'd0,
        ADJ_SHORTEN  = 2'd1,
        ADJ_LENGTHEN = 2'd2
    } adj_e;

    typedef struct packed {
        logic empty;
        logic full;
    } occ_flags_t;

    // Decide the direction of the next period correction from the fill level.
    function automatic adj_e pick_adj(input int unsigned fill,
                                      input int unsigned mid,
                                      input int unsigned tol);
        if (fill > mid + tol)
            return ADJ_SHORTEN;
        else if (fill + tol < mid)
            return ADJ_LENGTHEN;
        else
            return ADJ_HOLD;
    endfunction

endpackage

// File: rtl/rf_occupancy.sv
module rf_occupancy
    import rate_follow_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int OCC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx,
    input  logic             tx,
    output logic [OCC_W-1:0] occ,
    output occ_flags_t       flags
);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    logic at_full, at_empty, up, dn;

    assign at_full  = (occ == FULL);
    assign at_empty = (occ == '0);
    assign up       = rx & ~tx & ~at_full;
    assign dn       = tx & ~rx & ~at_empty;

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else if (up)
            occ <= occ + OCC_W'(1);
        else if (dn)
            occ <= occ - OCC_W'(1);
    end

    assign flags.empty = at_empty;
    assign flags.full  = at_full;

    // R1
    a_r1_increment: assert property (@(posedge clk) disable iff (rst)
        (rx && !tx && !flags.full) |=> (occ == $past(occ) + OCC_W'(1)));
    // R2
    a_r2_balanced_hold: assert property (@(posedge clk) disable iff (rst)
        (rx == tx) |=> $stable(occ));
    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (flags.full && rx && !tx) |=> flags.full);
    // R4
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (flags.empty && tx && !rx) |=> flags.empty);

endmodule

// File: rtl/rf_trim.sv
module rf_trim
    import rate_follow_pkg::*;
#(
    parameter int          RELOAD_W  = 20,
    parameter int          STEP_W    = 8,
    parameter int          OCC_W     = 4,
    parameter int unsigned SETPOINT  = 6,
    parameter int          MS_CYCLES = 125000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [OCC_W-1:0]    occ,
    input  logic [OCC_W-1:0]    band,
    input  logic [RELOAD_W-1:0] nominal,
    input  logic [STEP_W-1:0]   step,
    output logic [RELOAD_W-1:0] reload
);
    localparam int WIN_W = $clog2(MS_CYCLES);
    localparam int TW    = RELOAD_W + 2;

    logic [WIN_W-1:0]     wcnt;
    logic                 win_end;
    adj_e                 adj;
    logic signed [TW-1:0] trim, trim_nxt, lim_s, step_s, dec, inc, sum;

    assign win_end = (wcnt == WIN_W'(MS_CYCLES - 1));
    assign adj     = pick_adj(32'(occ), SETPOINT, 32'(band));

    always_ff @(posedge clk) begin
        if (rst)
            wcnt <= '0;
        else if (win_end)
            wcnt <= '0;
        else
            wcnt <= wcnt + WIN_W'(1);
    end

    always_comb begin
        lim_s  = $signed({2'b00, nominal / RELOAD_W'(100)});
        step_s = $signed({{(TW-STEP_W){1'b0}}, step});
        dec    = trim - step_s;
        inc    = trim + step_s;
        case (adj)
            ADJ_SHORTEN:  trim_nxt = (dec < -lim_s) ? -lim_s : dec;
            ADJ_LENGTHEN: trim_nxt = (inc > lim_s)  ? lim_s  : inc;
            default:      trim_nxt = trim;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            trim <= '0;
        else if (win_end)
            trim <= trim_nxt;
    end

    assign sum    = $signed({2'b00, nominal}) + trim;
    assign reload = sum[RELOAD_W-1:0];

    // R6
    a_r6_window_only: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(reload));
    // R9
    a_r9_band_hold: assert property (@(posedge clk) disable iff (rst)
        (win_end && adj == ADJ_HOLD) |=> $stable(reload));
    // R7 and R10
    a_r7_shorten: assert property (@(posedge clk) disable iff (rst)
        (win_end && adj == ADJ_SHORTEN && $stable(nominal))
        |=> (reload <= $past(reload)) && (trim >= -lim_s));
    // R8 and R10
    a_r8_lengthen: assert property (@(posedge clk) disable iff (rst)
        (win_end && adj == ADJ_LENGTHEN && $stable(nominal))
        |=> (reload >= $past(reload)) && (trim <= lim_s));

endmodule

// File: rtl/rf_tick_timer.sv
module rf_tick_timer #(
    parameter int RELOAD_W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);
    logic [RELOAD_W-1:0] cnt;

    assign tick = (cnt >= reload - RELOAD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= '0;
        else
            cnt <= cnt + RELOAD_W'(1);
    end

    // R11
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (tick && reload > RELOAD_W'(1) && $stable(reload)) |=> !tick);

endmodule

// File: rtl/rate_follower.sv
module rate_follower
    import rate_follow_pkg::*;
#(
    parameter int RELOAD_W      = 20,
    parameter int STEP_W        = 8,
    parameter int FRAMES_PER_MS = 4,
    parameter int BUF_MS        = 3,
    parameter int MS_CYCLES     = 125000,
    localparam int DEPTH        = FRAMES_PER_MS * BUF_MS,
    localparam int OCC_W        = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_frame,
    input  logic                tx_frame,
    input  logic [RELOAD_W-1:0] nominal_reload,
    input  logic [STEP_W-1:0]   trim_step,
    input  logic [OCC_W-1:0]    band,
    output logic [RELOAD_W-1:0] reload_out,
    output logic                send_tick,
    output logic [OCC_W-1:0]    occupancy,
    output logic                underflow,
    output logic                overflow
);
    localparam int unsigned SETPOINT = DEPTH / 2;

    occ_flags_t flags;

    rf_occupancy #(
        .DEPTH (DEPTH),
        .OCC_W (OCC_W)
    ) u_occ (
        .clk   (clk),
        .rst   (rst),
        .rx    (rx_frame),
        .tx    (tx_frame),
        .occ   (occupancy),
        .flags (flags)
    );

    rf_trim #(
        .RELOAD_W  (RELOAD_W),
        .STEP_W    (STEP_W),
        .OCC_W     (OCC_W),
        .SETPOINT  (SETPOINT),
        .MS_CYCLES (MS_CYCLES)
    ) u_trim (
        .clk     (clk),
        .rst     (rst),
        .occ     (occupancy),
        .band    (band),
        .nominal (nominal_reload),
        .step    (trim_step),
        .reload  (reload_out)
    );

    rf_tick_timer #(
        .RELOAD_W (RELOAD_W)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .reload (reload_out),
        .tick   (send_tick)
    );

    assign underflow = flags.empty;
    assign overflow  = flags.full;

endmodule

// File: tb/rate_follower_tb.sv
module rate_follower_tb;
    localparam int MS    = 16;
    localparam int NOM   = 1000;
    localparam int STEP  = 2;
    localparam int BANDV = 2;
    localparam int DEPTH = 12;
    localparam int SET   = 6;
    localparam int LIM   = NOM / 100;

    // rx, tx, cycles, expected occupancy afterwards
    localparam int VEC [0:6][0:3] = '{
        '{1, 0, 4, 4},
        '{1, 1, 3, 4},
        '{0, 1, 1, 3},
        '{1, 0, 20, 12},
        '{0, 0, 2, 12},
        '{0, 1, 20, 0},
        '{1, 0, 6, 6}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        rx = 0, tx = 0;
    logic [19:0] reload_out;
    logic        send_tick;
    logic [3:0]  occupancy;
    logic        underflow, overflow;

    int nchk = 0, nfail = 0;
    bit live = 0;
    bit done = 0;
    int m_occ = 0, m_win = 0, m_trim = 0;

    always #4 clk = ~clk;

    rate_follower #(.MS_CYCLES(MS)) u_dut (
        .clk(clk), .rst(rst), .rx_frame(rx), .tx_frame(tx),
        .nominal_reload(20'(NOM)), .trim_step(8'(STEP)), .band(4'(BANDV)),
        .reload_out(reload_out), .send_tick(send_tick), .occupancy(occupancy),
        .underflow(underflow), .overflow(overflow)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model built from the requirements
    always @(posedge clk) begin
        if (rst) begin
            m_occ <= 0; m_win <= 0; m_trim <= 0;
        end else begin
            if (rx && !tx && m_occ < DEPTH) m_occ <= m_occ + 1;
            else if (tx && !rx && m_occ > 0) m_occ <= m_occ - 1;
            if (m_win == MS - 1) begin
                m_win <= 0;
                if (m_occ > SET + BANDV)
                    m_trim <= (m_trim - STEP < -LIM) ? -LIM : m_trim - STEP;
                else if (m_occ + BANDV < SET)
                    m_trim <= (m_trim + STEP > LIM) ? LIM : m_trim + STEP;
            end else begin
                m_win <= m_win + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (live && !rst) begin
            chk("R1 R2 R3 R4 occupancy model", int'(occupancy), m_occ);
            chk("R6 R7 R8 R9 R10 reload model", int'(reload_out), NOM + m_trim);
        end
    end

    task automatic drive(input bit r, input bit t, input int n);
        for (int i = 0; i < n; i++) begin
            rx = r; tx = t;
            @(negedge clk);
        end
        rx = 0; tx = 0;
    endtask

    task automatic idle(input int n);
        rx = 0; tx = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_occ(input int target);
        int cur;
        cur = int'(occupancy);
        if (target > cur) drive(1, 0, target - cur);
        else if (target < cur) drive(0, 1, cur - target);
    endtask

    task automatic tick_gap(input int exp);
        int n;
        while (!send_tick) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!send_tick);
        chk("R11 tick interval", n, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        int r0, prev, changes;
        repeat (3) @(negedge clk);
        // R5 reset state
        chk("R5 reset occupancy", int'(occupancy), 0);
        chk("R5 reset underflow", int'(underflow), 1);
        chk("R5 reset overflow", int'(overflow), 0);
        chk("R5 reset reload", int'(reload_out), NOM);
        chk("R5 reset tick", int'(send_tick), 0);
        rst = 0;
        live = 1;

        for (int v = 0; v < 7; v++) begin
            drive(VEC[v][0][0], VEC[v][1][0], VEC[v][2]);
            chk("R1 R2 R3 R4 table occupancy", int'(occupancy), VEC[v][3]);
            chk("R3 table overflow flag", int'(overflow), (VEC[v][3] == DEPTH) ? 1 : 0);
            chk("R4 table underflow flag", int'(underflow), (VEC[v][3] == 0) ? 1 : 0);
        end

        // R9 upper band edge: no change
        set_occ(SET + BANDV);
        r0 = int'(reload_out);
        idle(2 * MS);
        chk("R9 upper band edge hold", int'(reload_out), r0);
        // R7 one above band: one shorten step
        set_occ(SET + BANDV + 1);
        r0 = int'(reload_out);
        idle(MS);
        chk("R7 shorten one step", int'(reload_out), (r0 - STEP < NOM - LIM) ? NOM - LIM : r0 - STEP);
        // R9 lower band edge
        set_occ(SET - BANDV);
        r0 = int'(reload_out);
        idle(2 * MS);
        chk("R9 lower band edge hold", int'(reload_out), r0);
        // R8 one below band
        set_occ(SET - BANDV - 1);
        r0 = int'(reload_out);
        idle(MS);
        chk("R8 lengthen one step", int'(reload_out), (r0 + STEP > NOM + LIM) ? NOM + LIM : r0 + STEP);

        // R10 upper clamp, R4 empty, R11 period
        set_occ(0);
        idle(12 * MS);
        chk("R10 upper trim bound", int'(reload_out), NOM + LIM);
        chk("R4 underflow held", int'(underflow), 1);
        tick_gap(NOM + LIM);

        // R10 lower clamp, R3 full, R11 period
        set_occ(DEPTH);
        idle(15 * MS);
        chk("R10 lower trim bound", int'(reload_out), NOM - LIM);
        chk("R3 overflow held", int'(overflow), 1);
        tick_gap(NOM - LIM);

        // R6 one step per window
        set_occ(0);
        r0 = int'(reload_out);
        prev = r0;
        changes = 0;
        for (int i = 0; i < 4 * MS; i++) begin
            @(negedge clk);
            if (int'(reload_out) != prev) begin
                changes++;
                prev = int'(reload_out);
            end
        end
        chk("R6 adjustments in four windows", changes, 4);
        chk("R8 total after four windows", int'(reload_out), r0 + 4 * STEP);

        // R5 reset mid-run
        set_occ(5);
        rst = 1;
        repeat (2) @(negedge clk);
        chk("R5 mid-run reset occupancy", int'(occupancy), 0);
        chk("R5 mid-run reset reload", int'(reload_out), NOM);
        chk("R5 mid-run reset underflow", int'(underflow), 1);
        rst = 0;
        idle(4);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule